// File: doc/BRIEF.md
# Result Gather Controller

This block sits at the output side of an array of processing channels, each holding several cores. A host programs the frame geometry and the filter operation through a small AXI4-Lite-style register port, then starts a run. While the run lasts, the gather engine takes one result word at a time from the cores. It visits every core of a channel before it moves on to the next channel. Each word goes out on a single AXI4-Stream master port. When width times height words have gone out, the run ends.

The sequencer has two states. ST_IDLE waits for a start command. ST_RUN gathers words. There are two transitions. "launch" goes from ST_IDLE to ST_RUN on a start command that is accepted. "finish" goes from ST_RUN to ST_IDLE on the handshake of the final word. A start command that cannot be honoured changes no state and raises a sticky error flag instead. The operation chosen at launch is held on an output for the cores until the run ends.

The register port takes an address and its data together, has no byte strobes and answers every access with an OKAY response.

Top module: `result_gather_unit`

## Requirements
- R1: The register at 0x0 reads back what was written: width in bits [7:0], height in bits [15:8], operation code in bits [17:16] (bit 16: 0 = 3x3 kernel, 1 = 5x5; bit 17: 0 = grayscale, 1 = colour). The register at 0x4 reads {error at bit 1, busy at bit 0}. Reads of 0x8 return zero. Writes to 0x4 have no effect.
- R2: A write of any data to 0x8 while idle, with nonzero width and height, starts a run. Busy reads 1 from the clock edge of that write onward, the error bit clears, and `run_op` takes bits [17:16] of 0x0.
- R3: A write to 0x8 while width or height is zero sets the error bit, leaves busy at 0 and produces no output word.
- R4: A write to 0x8 during a run is ignored and sets the error bit. The run goes on with its original word count.
- R5: Output word n comes from the core with flat index n mod (channels x cores), where flat index = channel x cores + core. The core index wraps first, then the channel index. While busy and `m_tready` is high, only that core's `core_ready` bit is set.
- R6: The engine moves on only after a handshake (`m_tvalid` and `m_tready`). A stalled core or a low `m_tready` never skips a word.
- R7: A run emits exactly width x height words. `m_tlast` is high on the final word only. Busy reads 0 after the clock edge of that word's handshake.
- R8: While idle, `m_tvalid` and every `core_ready` bit are 0.
- R9: `run_op` stays constant for the whole run, even if 0x0 is rewritten during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_valid | input | NUM_CH*CORES_PER_CH | Result valid, one bit per core |
| core_data | input | NUM_CH*CORES_PER_CH*DATA_W | Result words, core k in slice k |
| core_ready | output | NUM_CH*CORES_PER_CH | Result taken, one bit per core |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | DATA_W | Output stream data |
| m_tlast | output | 1 | Final word of the frame |
| run_op | output | 2 | Operation code latched at launch |

## Verification
The stream path is combinational from the selected core to the port. The bench therefore changes the core and sink inputs at the falling edge, waits one time unit, and checks the word, `m_tlast` and the one-hot `core_ready` in the same cycle. The word counter moves on at the next rising edge. Busy, error and `run_op` change at the same rising edge that completes the write to 0x8. A status read takes two more edges, so busy is checked only on frames long enough to still be running, while error and `run_op` are checked right after the write. The end of the run is checked by polling status after the last word and comparing the counted words with width x height.

// File: rtl/gather_pkg.sv
package gather_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gather_state_e;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;
    localparam int OP_W   = 2;

    localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
    localparam logic [REG_AW-1:0] OFS_STAT = 4'h4;
    localparam logic [REG_AW-1:0] OFS_GO   = 4'h8;
endpackage

// File: rtl/gather_regs.sv
module gather_regs
    import gather_pkg::*;
#(
    parameter int DIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [REG_DW-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [REG_AW-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [REG_DW-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    input  logic              busy,
    input  logic              err,
    output logic [DIM_W-1:0]  cfg_w,
    output logic [DIM_W-1:0]  cfg_h,
    output logic [OP_W-1:0]   cfg_op,
    output logic              go_pulse
);
    localparam int CTRL_W = 2 * DIM_W + OP_W;

    logic wr_fire;
    logic rd_fire;
    logic [CTRL_W-1:0] ctrl_word;
    logic unused_wbits;

    // Address and data are accepted together, only while no response is pending.
    assign awready  = wvalid && !bvalid;
    assign wready   = awvalid && !bvalid;
    assign wr_fire  = awvalid && wvalid && !bvalid;
    assign arready  = !rvalid;
    assign rd_fire  = arvalid && !rvalid;
    assign go_pulse = wr_fire && (awaddr == OFS_GO);
    assign ctrl_word = {cfg_op, cfg_h, cfg_w};
    assign unused_wbits = ^wdata[REG_DW-1:CTRL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_w  <= '0;
            cfg_h  <= '0;
            cfg_op <= '0;
        end else if (wr_fire && (awaddr == OFS_CTRL)) begin
            cfg_w  <= wdata[DIM_W-1:0];
            cfg_h  <= wdata[2*DIM_W-1:DIM_W];
            cfg_op <= wdata[2*DIM_W +: OP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bvalid <= 1'b0;
        end else if (wr_fire) begin
            bvalid <= 1'b1;
        end else if (bready) begin
            bvalid <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            unique case (araddr)
                OFS_CTRL: rdata <= REG_DW'(ctrl_word);
                OFS_STAT: rdata <= REG_DW'({err, busy});
                default:  rdata <= '0;
            endcase
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
    import gather_pkg::*;
#(
    parameter int NUM_CH       = 2,
    parameter int CORES_PER_CH = 3,
    parameter int DIM_W        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go_pulse,
    input  logic [DIM_W-1:0]       cfg_w,
    input  logic [DIM_W-1:0]       cfg_h,
    input  logic [OP_W-1:0]        cfg_op,
    input  logic                   xfer,
    output logic                   busy,
    output logic                   err,
    output logic [(NUM_CH > 1 ? $clog2(NUM_CH) : 1)-1:0]             ch_idx,
    output logic [(CORES_PER_CH > 1 ? $clog2(CORES_PER_CH) : 1)-1:0] core_idx,
    output logic                   last_word,
    output logic [OP_W-1:0]        run_op
);
    localparam int CH_W  = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
    localparam int CO_W  = CORES_PER_CH > 1 ? $clog2(CORES_PER_CH) : 1;
    localparam int PIX_W = 2 * DIM_W;

    gather_state_e state, state_n;
    logic              go_ok;
    logic [PIX_W-1:0]  total_q;
    logic [PIX_W-1:0]  pix_q;
    logic [CH_W-1:0]   ch_q;
    logic [CO_W-1:0]   core_q;
    logic              core_wrap;

    assign go_ok     = go_pulse && (state == ST_IDLE) && (|cfg_w) && (|cfg_h);
    assign busy      = (state == ST_RUN);
    assign last_word = (pix_q == total_q - PIX_W'(1));
    assign core_wrap = (core_q == CO_W'(CORES_PER_CH - 1));
    assign ch_idx    = ch_q;
    assign core_idx  = core_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Transitions: launch (IDLE->RUN), finish (RUN->IDLE).
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (go_ok)             state_n = ST_RUN;
            ST_RUN:  if (xfer && last_word) state_n = ST_IDLE;
        endcase
    end

    // Flags, latched run settings and the two rotation counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err     <= 1'b0;
            total_q <= '0;
            pix_q   <= '0;
            ch_q    <= '0;
            core_q  <= '0;
            run_op  <= '0;
        end else begin
            if (go_pulse) begin
                err <= !go_ok;
            end
            if (go_ok) begin
                total_q <= PIX_W'(cfg_w) * PIX_W'(cfg_h);
                pix_q   <= '0;
                ch_q    <= '0;
                core_q  <= '0;
                run_op  <= cfg_op;
            end else if (busy && xfer) begin
                pix_q <= pix_q + PIX_W'(1);
                if (core_wrap) begin
                    core_q <= '0;
                    ch_q   <= (ch_q == CH_W'(NUM_CH - 1)) ? '0 : ch_q + CH_W'(1);
                end else begin
                    core_q <= core_q + CO_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/gather_mux.sv
module gather_mux #(
    parameter int NUM_CH       = 2,
    parameter int CORES_PER_CH = 3,
    parameter int DATA_W       = 16
) (
    input  logic [NUM_CH*CORES_PER_CH-1:0]        core_valid,
    input  logic [NUM_CH*CORES_PER_CH*DATA_W-1:0] core_data,
    output logic [NUM_CH*CORES_PER_CH-1:0]        core_ready,
    input  logic [(NUM_CH > 1 ? $clog2(NUM_CH) : 1)-1:0]             ch_idx,
    input  logic [(CORES_PER_CH > 1 ? $clog2(CORES_PER_CH) : 1)-1:0] core_idx,
    input  logic                                  busy,
    input  logic                                  last_word,
    input  logic                                  m_tready,
    output logic                                  m_tvalid,
    output logic [DATA_W-1:0]                     m_tdata,
    output logic                                  m_tlast,
    output logic                                  xfer
);
    localparam int N_SRC = NUM_CH * CORES_PER_CH;
    localparam int SEL_W = N_SRC > 1 ? $clog2(N_SRC) + 1 : 1;

    logic [SEL_W-1:0] sel;
    logic             sel_valid;

    assign sel = SEL_W'(ch_idx) * SEL_W'(CORES_PER_CH) + SEL_W'(core_idx);

    always_comb begin
        sel_valid = 1'b0;
        m_tdata   = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (sel == SEL_W'(k)) begin
                sel_valid = core_valid[k];
                m_tdata   = core_data[k*DATA_W +: DATA_W];
            end
        end
    end

    assign m_tvalid = busy && sel_valid;
    assign m_tlast  = m_tvalid && last_word;
    assign xfer     = m_tvalid && m_tready;

    for (genvar k = 0; k < N_SRC; k++) begin : g_ready
        assign core_ready[k] = busy && m_tready && (sel == SEL_W'(k));
    end
endmodule

// File: rtl/result_gather_unit.sv
module result_gather_unit
    import gather_pkg::*;
#(
    parameter int NUM_CH       = 2,
    parameter int CORES_PER_CH = 3,
    parameter int DATA_W       = 16,
    parameter int DIM_W        = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [REG_AW-1:0]                     s_awaddr,
    input  logic                                  s_awvalid,
    output logic                                  s_awready,
    input  logic [REG_DW-1:0]                     s_wdata,
    input  logic                                  s_wvalid,
    output logic                                  s_wready,
    output logic [1:0]                            s_bresp,
    output logic                                  s_bvalid,
    input  logic                                  s_bready,
    input  logic [REG_AW-1:0]                     s_araddr,
    input  logic                                  s_arvalid,
    output logic                                  s_arready,
    output logic [REG_DW-1:0]                     s_rdata,
    output logic [1:0]                            s_rresp,
    output logic                                  s_rvalid,
    input  logic                                  s_rready,
    input  logic [NUM_CH*CORES_PER_CH-1:0]        core_valid,
    input  logic [NUM_CH*CORES_PER_CH*DATA_W-1:0] core_data,
    output logic [NUM_CH*CORES_PER_CH-1:0]        core_ready,
    output logic                                  m_tvalid,
    input  logic                                  m_tready,
    output logic [DATA_W-1:0]                     m_tdata,
    output logic                                  m_tlast,
    output logic [OP_W-1:0]                       run_op
);
    localparam int N_SRC = NUM_CH * CORES_PER_CH;
    localparam int CH_W  = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
    localparam int CO_W  = CORES_PER_CH > 1 ? $clog2(CORES_PER_CH) : 1;

    logic             busy;
    logic             err;
    logic             go_pulse;
    logic             xfer;
    logic             last_word;
    logic [DIM_W-1:0] cfg_w;
    logic [DIM_W-1:0] cfg_h;
    logic [OP_W-1:0]  cfg_op;
    logic [CH_W-1:0]  ch_idx;
    logic [CO_W-1:0]  core_idx;

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    gather_regs #(.DIM_W(DIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
        .busy(busy), .err(err),
        .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_op(cfg_op), .go_pulse(go_pulse)
    );

    gather_seq #(.NUM_CH(NUM_CH), .CORES_PER_CH(CORES_PER_CH), .DIM_W(DIM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_pulse(go_pulse),
        .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_op(cfg_op), .xfer(xfer),
        .busy(busy), .err(err), .ch_idx(ch_idx), .core_idx(core_idx),
        .last_word(last_word), .run_op(run_op)
    );

    gather_mux #(.NUM_CH(NUM_CH), .CORES_PER_CH(CORES_PER_CH), .DATA_W(DATA_W)) u_mux (
        .core_valid(core_valid), .core_data(core_data), .core_ready(core_ready),
        .ch_idx(ch_idx), .core_idx(core_idx), .busy(busy), .last_word(last_word),
        .m_tready(m_tready), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .xfer(xfer)
    );
endmodule

// File: rtl/gather_checks.sv
module gather_checks
    import gather_pkg::*;
#(
    parameter int N_SRC = 6,
    parameter int DIM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             err,
    input logic             go_pulse,
    input logic [DIM_W-1:0] cfg_w,
    input logic [DIM_W-1:0] cfg_h,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic             m_tlast,
    input logic [N_SRC-1:0] core_ready,
    input logic [OP_W-1:0]  run_op
);
    a_r2_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse && !busy && cfg_w != '0 && cfg_h != '0) |=> (busy && !err));

    a_r3_zero_dim_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse && !busy && (cfg_w == '0 || cfg_h == '0)) |=> (!busy && err));

    a_r4_go_busy_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse && busy && !(m_tvalid && m_tready && m_tlast)) |=> (busy && err));

    a_r5_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_ready));

    a_r7_last_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> !busy);

    a_r7_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_tvalid && core_ready == '0));

    a_r9_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(run_op));
endmodule

bind result_gather_unit gather_checks #(.N_SRC(N_SRC), .DIM_W(DIM_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .go_pulse(go_pulse),
    .cfg_w(cfg_w), .cfg_h(cfg_h), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .core_ready(core_ready), .run_op(run_op)
);

// File: tb/tb_result_gather_unit.sv
module tb_result_gather_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int CPC    = 3;
    localparam int N      = NUM_CH * CPC;
    localparam int DW     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [3:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [N-1:0]    core_valid = '0;
    logic [N*DW-1:0] core_data = '0;
    logic [N-1:0]    core_ready;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic [DW-1:0] m_tdata;
    logic        m_tlast;
    logic [1:0]  run_op;

    result_gather_unit #(.NUM_CH(NUM_CH), .CORES_PER_CH(CPC), .DATA_W(DW), .DIM_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .core_valid(core_valid), .core_data(core_data), .core_ready(core_ready),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .run_op(run_op)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int seq [N];
    int words = 0;
    int total = 0;
    int vmod = 0;
    int rmod = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0; d = s_rdata; s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 3000; i++) begin
            reg_read(4'h4, st);
            if (st[0] == 1'b0) break;
        end
    endtask

    // Core and sink model; checks every output word in the cycle it is offered.
    initial begin
        for (int k = 0; k < N; k++) seq[k] = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < N; k++) begin
                core_valid[k] = (vmod == 0) ? 1'b1 : (((cyc + 3 * k) % vmod) != 0);
                core_data[k*DW +: DW] = {4'(k), 12'(seq[k])};
            end
            m_tready = (rmod == 0) ? 1'b1 : ((cyc % rmod) != 0);
            #1;
            if (m_tready && core_ready != '0) begin
                // R5: only the core due next is offered ready, stalls included
                chk(core_ready == N'(1 << (words % N)), "R5 ready one-hot on due core",
                    core_ready, 1 << (words % N));
            end
            if (m_tvalid && m_tready) begin
                int e;
                e = words % N;
                chk(m_tdata == {4'(e), 12'(seq[e])}, "R5/R6 word source and order",
                    m_tdata, {4'(e), 12'(seq[e])});
                chk(m_tlast == (words == total - 1), "R7 tlast on final word only",
                    m_tlast, words == total - 1);
                seq[e]++;
                words++;
            end
        end
    end

    task automatic run_frame(input int w, input int h, input int op, input int vm, input int rm);
        logic [31:0] r;
        reg_write(4'h0, {14'd0, 2'(op), 8'(h), 8'(w)});
        reg_read(4'h0, r);
        chk(r == {14'd0, 2'(op), 8'(h), 8'(w)}, "R1 ctrl readback", r, {14'd0, 2'(op), 8'(h), 8'(w)});
        words = 0; total = w * h; vmod = vm; rmod = rm;
        reg_write(4'h8, 32'h0);
        chk(run_op == 2'(op), "R2 run_op latched at launch", run_op, op);
        reg_read(4'h4, r);
        chk(r[1] == 1'b0, "R2 error clear after accepted go", r[1], 0);
        if (total >= 12) chk(r[0] == 1'b1, "R2 busy during run", r[0], 1);
        wait_idle();
        chk(words == total, "R7 word count equals w*h", words, total);
        @(negedge clk); #1;
        chk(!m_tvalid && core_ready == '0, "R8 idle outputs quiet", {m_tvalid, core_ready}, 0);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!m_tvalid && core_ready == '0, "R8 reset quiet with cores valid", {m_tvalid, core_ready}, 0);
        reg_read(4'h4, r);
        chk(r == 32'h0, "R1 status after reset", r, 0);
        reg_read(4'h0, r);
        chk(r == 32'h0, "R1 ctrl after reset", r, 0);

        // R3: zero width, then zero height
        reg_write(4'h0, {14'd0, 2'd1, 8'd5, 8'd0});
        reg_write(4'h8, 32'h1);
        reg_read(4'h4, r);
        chk(r[1:0] == 2'b10, "R3 zero width fails", r[1:0], 2);
        reg_write(4'h0, {14'd0, 2'd0, 8'd0, 8'd4});
        reg_write(4'h8, 32'h1);
        repeat (5) @(negedge clk);
        reg_read(4'h4, r);
        chk(r[1:0] == 2'b10, "R3 zero height fails", r[1:0], 2);
        chk(words == 0, "R3 no output word", words, 0);

        // R1: go reads zero, status write has no effect
        reg_read(4'h8, r);
        chk(r == 32'h0, "R1 go register reads zero", r, 0);
        reg_write(4'h4, 32'h0);
        reg_read(4'h4, r);
        chk(r[1:0] == 2'b10, "R1 status write ignored", r[1:0], 2);

        run_frame(1, 1, 0, 0, 0);
        run_frame(2, 3, 1, 3, 0);
        run_frame(3, 7, 3, 5, 3);
        run_frame(6, 1, 2, 0, 2);

        // R4 and R9: disturb a long run
        reg_write(4'h0, {14'd0, 2'd2, 8'd5, 8'd4});
        words = 0; total = 20; vmod = 3; rmod = 4;
        reg_write(4'h8, 32'h0);
        reg_write(4'h0, {14'd0, 2'd1, 8'd1, 8'd1});
        chk(run_op == 2'd2, "R9 run_op held after ctrl rewrite", run_op, 2);
        reg_write(4'h8, 32'h0);
        reg_read(4'h4, r);
        chk(r[1:0] == 2'b11, "R4 go while busy flags error", r[1:0], 3);
        chk(run_op == 2'd2, "R9 run_op held after ignored go", run_op, 2);
        wait_idle();
        chk(words == 20, "R4 run keeps original count", words, 20);
        reg_read(4'h4, r);
        chk(r[1:0] == 2'b10, "R4 error sticky until next launch", r[1:0], 2);

        run_frame(4, 5, 1, 4, 0);
        run_frame(13, 1, 3, 2, 5);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", words, total);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule